// File: doc/BRIEF.md
# Overlap-Safe Rectangle Copy Engine

This block moves a rectangle of pixels from one place in a linear framebuffer to another place in the same buffer. The rectangle is given by its source corner (x0, y0), its destination corner (x1, y1), its width w and its height h, all in pixels. The engine turns pixel coordinates into byte addresses from two values: a fixed number of bytes per pixel and a fixed screen width. It then moves the rectangle one byte at a time through a simple synchronous memory port.

Source and destination may overlap. The engine picks the row order and the byte order inside each row so that every source byte is read before any write can overwrite it. The result is the same as reading the whole source rectangle first and writing it afterwards. When the last byte has been written, the engine reports the destination rectangle once on a damage output, so a display path can refresh that area. It then signals completion.

Top module: `rect_copy_engine`

## Requirements
- R1: After reset, busy_o, done_o, dmg_valid_o, mem_re_o and mem_we_o are all low.
- R2: The pitch is BPP*SCREEN_W bytes. Pixel (x, y) starts at byte BPP*x + pitch*y. Each row moves BPP*w bytes, so a command writes BPP*w*h bytes in total.
- R3: When y1 > y0, rows are moved bottom-up. The first write falls in destination row h-1, and both row bases step down by one pitch per row.
- R4: When y1 <= y0, rows are moved top-down. The first write falls in destination row 0, and both row bases step up by one pitch per row.
- R5: Inside a row, bytes are moved from the highest offset to the lowest when y1 == y0 and x1 > x0. In every other case they are moved from the lowest offset to the highest. In the first case the first write lands at offset BPP*w-1 of the row.
- R6: After a command, memory holds the result of an overlap-safe move: every destination byte equals the source byte as it was before the command began, and no byte outside the destination rectangle changes.
- R7: After the last write, dmg_valid_o is high for exactly one cycle, and dmg_x_o, dmg_y_o, dmg_w_o and dmg_h_o equal x1, y1, w and h.
- R8: For a non-empty command, busy_o goes high in the cycle after start_i is taken and stays high for 2*BPP*w*h+1 cycles, ending with the damage cycle. done_o is then high for exactly one cycle while busy_o is low. This puts done_o 2*BPP*w*h+2 cycles after the start edge.
- R9: A command with w == 0 or h == 0 makes no memory access and no damage push. busy_o stays low, and done_o pulses one cycle after the start edge.
- R10: start_i is ignored while busy_o is high. The running copy, its damage item and memory are unaffected by it.
- R11: Read data is taken one cycle after mem_re_o. Every write cycle directly follows a read cycle, reads and writes never share a cycle, and reads equal writes in number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command (taken when idle) |
| x0_i | input | COORD_W | Source x in pixels |
| y0_i | input | COORD_W | Source y in pixels |
| x1_i | input | COORD_W | Destination x in pixels |
| y1_i | input | COORD_W | Destination y in pixels |
| w_i | input | COORD_W | Width in pixels |
| h_i | input | COORD_W | Height in pixels |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_re_o | output | 1 | Memory read strobe |
| mem_raddr_o | output | ADDR_W | Memory read byte address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after mem_re_o |
| mem_we_o | output | 1 | Memory write strobe |
| mem_waddr_o | output | ADDR_W | Memory write byte address |
| mem_wdata_o | output | 8 | Write data |
| dmg_valid_o | output | 1 | Damage rectangle valid |
| dmg_x_o | output | COORD_W | Damage x |
| dmg_y_o | output | COORD_W | Damage y |
| dmg_w_o | output | COORD_W | Damage width |
| dmg_h_o | output | COORD_W | Damage height |

## Verification
The bench builds the engine with BPP = 2, SCREEN_W = 16, COORD_W = 6 and ADDR_W = 9, so the whole 16-row frame fits in 512 bytes that the bench models byte for byte. With two bytes per pixel, a single pixel spans several byte moves, so the byte order inside a row is exposed. With a 32-byte pitch, rectangles overlap when shifted down, up, left and right on the same line, and one command runs from the bottom-right pixel to the top-left pixel of the frame. The bench compares each command's whole frame with an overlap-safe reference copy. It also checks the first write address, the write count and the cycle count from start to done.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_PUSH,
    ST_FIN
  } rc_state_e;
endpackage

// File: rtl/rcopy_addr.sv
module rcopy_addr #(
  parameter int ADDR_W   = 24,
  parameter int COORD_W  = 12,
  parameter int BPP      = 4,
  parameter int SCREEN_W = 1024
) (
  input  logic [COORD_W-1:0] x0_i,
  input  logic [COORD_W-1:0] y0_i,
  input  logic [COORD_W-1:0] x1_i,
  input  logic [COORD_W-1:0] y1_i,
  input  logic [COORD_W-1:0] w_i,
  input  logic [COORD_W-1:0] h_i,
  output logic [ADDR_W-1:0]  src_base_o,
  output logic [ADDR_W-1:0]  dst_base_o,
  output logic [ADDR_W-1:0]  row_bytes_o,
  output logic               bottom_up_o,
  output logic               rtl_o,
  output logic               zero_o
);
  localparam logic [ADDR_W-1:0] BPP_A   = ADDR_W'(BPP);
  localparam logic [ADDR_W-1:0] PITCH_A = ADDR_W'(BPP * SCREEN_W);

  logic [ADDR_W-1:0] first_row;

  always_comb begin
    zero_o      = (w_i == '0) || (h_i == '0);
    bottom_up_o = y1_i > y0_i;
    rtl_o       = (y1_i == y0_i) && (x1_i > x0_i);
    first_row   = bottom_up_o ? ADDR_W'(h_i) - ADDR_W'(1) : '0;
    row_bytes_o = BPP_A * ADDR_W'(w_i);
    src_base_o  = BPP_A * ADDR_W'(x0_i) + PITCH_A * (ADDR_W'(y0_i) + first_row);
    dst_base_o  = BPP_A * ADDR_W'(x1_i) + PITCH_A * (ADDR_W'(y1_i) + first_row);
  end
endmodule

// File: rtl/rcopy_walk.sv
module rcopy_walk #(
  parameter int ADDR_W  = 24,
  parameter int COORD_W = 12,
  parameter int PITCH   = 4096
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               col_step_i,
  input  logic               row_step_i,
  input  logic [ADDR_W-1:0]  src_base_i,
  input  logic [ADDR_W-1:0]  dst_base_i,
  input  logic [ADDR_W-1:0]  row_bytes_i,
  input  logic [COORD_W-1:0] h_i,
  input  logic               bottom_up_i,
  input  logic               rtl_i,
  output logic [ADDR_W-1:0]  src_addr_o,
  output logic [ADDR_W-1:0]  dst_addr_o,
  output logic               col_last_o,
  output logic               row_last_o
);
  localparam logic [ADDR_W-1:0] PITCH_A = ADDR_W'(PITCH);

  logic [ADDR_W-1:0]  src_q, dst_q, col_q, nbytes_q, off;
  logic [COORD_W-1:0] row_q, h_q;
  logic               up_q, rtl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; col_q <= '0; nbytes_q <= '0;
      row_q <= '0; h_q <= '0; up_q <= 1'b0; rtl_q <= 1'b0;
    end else if (load_i) begin
      src_q    <= src_base_i;
      dst_q    <= dst_base_i;
      col_q    <= '0;
      row_q    <= '0;
      nbytes_q <= row_bytes_i;
      h_q      <= h_i;
      up_q     <= bottom_up_i;
      rtl_q    <= rtl_i;
    end else if (col_step_i) begin
      col_q <= col_q + ADDR_W'(1);
    end else if (row_step_i) begin
      col_q <= '0;
      row_q <= row_q + COORD_W'(1);
      src_q <= up_q ? src_q - PITCH_A : src_q + PITCH_A;
      dst_q <= up_q ? dst_q - PITCH_A : dst_q + PITCH_A;
    end
  end

  // byte offset inside the row, reversed for same-line moves to the right
  assign off        = rtl_q ? nbytes_q - col_q - ADDR_W'(1) : col_q;
  assign src_addr_o = src_q + off;
  assign dst_addr_o = dst_q + off;
  assign col_last_o = col_q == nbytes_q - ADDR_W'(1);
  assign row_last_o = row_q == h_q - COORD_W'(1);

  a_r2_row_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_step_i || row_step_i) |-> (row_q < h_q && col_q < nbytes_q));
  a_r2_step_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(col_step_i && row_step_i));
endmodule

// File: rtl/rcopy_ctrl.sv
module rcopy_ctrl
  import rcopy_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic zero_i,
  input  logic col_last_i,
  input  logic row_last_i,
  output logic load_o,
  output logic col_step_o,
  output logic row_step_o,
  output logic rd_o,
  output logic wr_o,
  output logic push_o,
  output logic busy_o,
  output logic done_o
);
  rc_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    col_step_o = 1'b0;
    row_step_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        state_d = zero_i ? ST_FIN : ST_RD;
      end
      ST_RD:   state_d = ST_WR;
      ST_WR: begin
        if (!col_last_i) begin
          col_step_o = 1'b1;
          state_d    = ST_RD;
        end else if (!row_last_i) begin
          row_step_o = 1'b1;
          state_d    = ST_RD;
        end else begin
          state_d = ST_PUSH;
        end
      end
      ST_PUSH: state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign rd_o   = state_q == ST_RD;
  assign wr_o   = state_q == ST_WR;
  assign push_o = state_q == ST_PUSH;
  assign done_o = state_q == ST_FIN;
  assign busy_o = rd_o || wr_o || push_o;

  a_r11_rd_then_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o);
  a_r8_push_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> done_o);
endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine #(
  parameter int ADDR_W   = 24,
  parameter int COORD_W  = 12,
  parameter int BPP      = 4,
  parameter int SCREEN_W = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COORD_W-1:0] x0_i,
  input  logic [COORD_W-1:0] y0_i,
  input  logic [COORD_W-1:0] x1_i,
  input  logic [COORD_W-1:0] y1_i,
  input  logic [COORD_W-1:0] w_i,
  input  logic [COORD_W-1:0] h_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mem_re_o,
  output logic [ADDR_W-1:0]  mem_raddr_o,
  input  logic [7:0]         mem_rdata_i,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_waddr_o,
  output logic [7:0]         mem_wdata_o,
  output logic               dmg_valid_o,
  output logic [COORD_W-1:0] dmg_x_o,
  output logic [COORD_W-1:0] dmg_y_o,
  output logic [COORD_W-1:0] dmg_w_o,
  output logic [COORD_W-1:0] dmg_h_o
);
  localparam int PITCH = BPP * SCREEN_W;

  logic [ADDR_W-1:0] src_base, dst_base, row_bytes;
  logic bottom_up, rtl, zero;
  logic load, col_step, row_step, col_last, row_last;

  rcopy_addr #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .BPP(BPP), .SCREEN_W(SCREEN_W)) u_addr (
    .x0_i, .y0_i, .x1_i, .y1_i, .w_i, .h_i,
    .src_base_o(src_base), .dst_base_o(dst_base), .row_bytes_o(row_bytes),
    .bottom_up_o(bottom_up), .rtl_o(rtl), .zero_o(zero)
  );

  rcopy_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .zero_i(zero),
    .col_last_i(col_last), .row_last_i(row_last),
    .load_o(load), .col_step_o(col_step), .row_step_o(row_step),
    .rd_o(mem_re_o), .wr_o(mem_we_o), .push_o(dmg_valid_o),
    .busy_o, .done_o
  );

  rcopy_walk #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .PITCH(PITCH)) u_walk (
    .clk_i, .rst_ni, .load_i(load), .col_step_i(col_step), .row_step_i(row_step),
    .src_base_i(src_base), .dst_base_i(dst_base), .row_bytes_i(row_bytes),
    .h_i, .bottom_up_i(bottom_up), .rtl_i(rtl),
    .src_addr_o(mem_raddr_o), .dst_addr_o(mem_waddr_o),
    .col_last_o(col_last), .row_last_o(row_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dmg_x_o <= '0; dmg_y_o <= '0; dmg_w_o <= '0; dmg_h_o <= '0;
    end else if (load) begin
      dmg_x_o <= x1_i; dmg_y_o <= y1_i; dmg_w_o <= w_i; dmg_h_o <= h_i;
    end
  end

  assign mem_wdata_o = mem_rdata_i;

  a_r11_rw_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  a_r11_wr_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_re_o && !mem_we_o && !dmg_valid_o));
  a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r7_dmg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(dmg_x_o) && $stable(dmg_y_o));
endmodule

// File: tb/rect_copy_engine_test.sv
module rect_copy_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W   = 9;
  localparam int COORD_W  = 6;
  localparam int BPP      = 2;
  localparam int SCREEN_W = 16;
  localparam int PITCH    = BPP * SCREEN_W;
  localparam int MEM_B    = 512;

  typedef struct packed {
    logic [COORD_W-1:0] x, y, w, h;
  } dmg_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [COORD_W-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0, w = '0, h = '0;
  logic busy, done, re, we, dvalid;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [7:0] rdata = 8'h00, wdata;
  logic [COORD_W-1:0] dx, dy, dw, dh;

  logic [7:0] mem  [MEM_B];
  logic [7:0] gold [MEM_B];
  dmg_t exp_q[$];

  int total = 0, bad = 0;
  int busy_cnt, wr_cnt, rd_cnt, dmg_cnt, first_waddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rect_copy_engine #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .BPP(BPP), .SCREEN_W(SCREEN_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .x0_i(x0), .y0_i(y0), .x1_i(x1), .y1_i(y1), .w_i(w), .h_i(h),
    .busy_o(busy), .done_o(done),
    .mem_re_o(re), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata),
    .dmg_valid_o(dvalid), .dmg_x_o(dx), .dmg_y_o(dy), .dmg_w_o(dw), .dmg_h_o(dh)
  );

  always @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: counts activity and pops the scoreboard on each damage push
  always @(negedge clk) begin
    if (rst_ni) begin
      if (busy) busy_cnt++;
      if (re) rd_cnt++;
      if (we) begin
        if (wr_cnt == 0) first_waddr = int'(waddr);
        wr_cnt++;
      end
      if (dvalid) begin
        dmg_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected damage push", 1, 0);
        else begin
          automatic dmg_t e = exp_q.pop_front();
          automatic dmg_t a = '{x: dx, y: dy, w: dw, h: dh};
          chk(a == e, "R7", "damage rectangle", int'(a), int'(e));
        end
      end
    end
  end

  task automatic run_cmd(input int sx, input int sy, input int tx, input int ty,
                         input int cw, input int ch, input bit poke);
    automatic logic [7:0] tmp[$];
    automatic int n = BPP * cw * ch;
    automatic bit zero = (cw == 0) || (ch == 0);
    automatic bit up = ty > sy;
    automatic bit rev = (ty == sy) && (tx > sx);
    automatic int row = up ? ch - 1 : 0;
    automatic int exp_first = BPP * tx + PITCH * (ty + row) + (rev ? BPP * cw - 1 : 0);
    automatic string otag = rev || (ty == sy) ? "R5" : (up ? "R3" : "R4");
    automatic int lat = 1;
    automatic int mism = 0;
    // reference: read whole source first, then write
    for (int r = 0; r < ch; r++)
      for (int b = 0; b < BPP * cw; b++) tmp.push_back(gold[BPP*sx + PITCH*(sy+r) + b]);
    for (int r = 0; r < ch; r++)
      for (int b = 0; b < BPP * cw; b++) gold[BPP*tx + PITCH*(ty+r) + b] = tmp.pop_front();
    if (!zero) exp_q.push_back('{x: COORD_W'(tx), y: COORD_W'(ty), w: COORD_W'(cw), h: COORD_W'(ch)});
    busy_cnt = 0; wr_cnt = 0; rd_cnt = 0; dmg_cnt = 0; first_waddr = -1;
    x0 = COORD_W'(sx); y0 = COORD_W'(sy); x1 = COORD_W'(tx); y1 = COORD_W'(ty);
    w = COORD_W'(cw); h = COORD_W'(ch); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 5000) begin
      if (poke && lat == 3) begin
        start = 1'b1; x0 = 0; y0 = 0; x1 = 9; y1 = 12; w = 3; h = 2;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (zero) chk(lat == 1, "R9", "start-to-done cycles", lat, 1);
    else      chk(lat == 2 * n + 2, "R8", "start-to-done cycles", lat, 2 * n + 2);
    chk(busy_cnt == (zero ? 0 : 2 * n + 1), zero ? "R9" : "R8", "busy cycles", busy_cnt, zero ? 0 : 2 * n + 1);
    chk(wr_cnt == n, "R2", "bytes written", wr_cnt, n);
    chk(rd_cnt == wr_cnt, "R11", "reads vs writes", rd_cnt, wr_cnt);
    if (!zero) chk(first_waddr == exp_first, otag, "first write address", first_waddr, exp_first);
    chk(dmg_cnt == (zero ? 0 : 1), poke ? "R10" : "R7", "damage pushes", dmg_cnt, zero ? 0 : 1);
    @(negedge clk);
    chk(!done && !busy, "R8", "done single pulse", int'(done), 0);
    for (int i = 0; i < MEM_B; i++) if (mem[i] !== gold[i]) mism++;
    chk(mism == 0, poke ? "R10" : "R6", "frame bytes differing", mism, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_B; i++) begin
      mem[i]  = 8'((i * 7 + 3) ^ (i >> 3));
      gold[i] = 8'((i * 7 + 3) ^ (i >> 3));
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !dvalid && !re && !we, "R1", "outputs in reset", int'({busy, done, dvalid, re, we}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !dvalid && !re && !we, "R1", "outputs after reset", int'({busy, done, dvalid, re, we}), 0);
    run_cmd(1, 1, 5, 8, 3, 2, 1'b0);    // disjoint, downward
    run_cmd(2, 2, 3, 4, 5, 4, 1'b0);    // overlap, dest below: R3
    run_cmd(3, 6, 1, 3, 4, 5, 1'b0);    // overlap, dest above: R4
    run_cmd(2, 5, 4, 5, 6, 3, 1'b0);    // same line, to the right: R5
    run_cmd(6, 9, 3, 9, 5, 2, 1'b0);    // same line, to the left: R5
    run_cmd(4, 4, 7, 7, 0, 3, 1'b0);    // zero width: R9
    run_cmd(4, 4, 7, 7, 3, 0, 1'b0);    // zero height: R9
    run_cmd(1, 10, 2, 11, 4, 3, 1'b1);  // start while busy: R10
    run_cmd(15, 15, 0, 0, 1, 1, 1'b0);  // frame corners
    chk(exp_q.size() == 0, "R7", "scoreboard left over", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule